// File: doc/BRIEF.md
# Paged Display RAM Access Controller

This block lets a host processor read and write a byte-organised display memory of 10 pages by 132 columns. A page holds eight pixel rows, so the memory covers 80 rows. The host reaches the memory over an 8-bit parallel bus. That bus has a select line that separates commands from display data, two chip selects, and a strap that picks between two timing styles. In the first style, separate active-low read and write strobes are used. In the second, an enable pulse is qualified by a read/write level. Every strobe is brought into the system clock through a two-stage synchroniser, and each access is acted on once, at the detected edge of its strobe.

The block holds three settings: a page register, a column register and a segment-mirror bit. Three commands load them. Every display-data read or write moves the column forward by one, and the column stops at the last column. All host data passes through a single holding byte. A write lands in this byte and is committed to memory on the following clock. A read hands the host the byte already held, then reloads it from the current address. Because of this, the first read after an address change or after a write returns stale data.

A second, read-only port serves the display scan logic. That logic presents a page and a segment index, and one clock later it receives the stored byte. The mirror bit decides whether segments map to columns in ascending or descending order.

Top module: `disp_ram_port`

## Requirements
- R1: The memory holds PAGES×COLS bytes (default 10×132), each addressed by a page (0..9) and a column (0..131).
- R2: The column advances by one after each display-data read or write, and it saturates at 131 rather than wrapping.
- R3: Command 8'b1011_pppp sets the page when pppp is below 10. Values of 10 or more leave the page unchanged. Auto-increment of the column never changes the page.
- R4: Command 8'b0000_llll replaces the low nibble of the column, and command 8'b0001_hhhh replaces the high nibble. A resulting value above 131 is clamped to 131.
- R5: A data write (A0=1) places the byte at the current page and column, and the byte is visible at the scan port before the next host access.
- R6: A data read returns the byte in the holding latch and then reloads the latch from the current address. A data write also loads the written byte into the latch.
- R7: The chip is selected only when cs1_n=0 and cs2=1. While it is deselected, d_oe stays 0 and strobes change neither memory nor address.
- R8: With mode_68=0, a read is active while rd_e is low (d_oe=1), and a write is taken at the rising edge of wr_rw.
- R9: With mode_68=1, a read is active while rd_e is high and wr_rw is high, and a write is taken at the falling edge of rd_e while wr_rw is low.
- R10: A read with A0=0 returns the status byte 8'h00, in which bit 7 (busy) is 0. It moves neither the column nor the holding latch.
- R11: Command 8'b1010_000m sets the mirror bit. One clock after scan_page/scan_seg are presented, scan_data equals the byte at column seg (m=0) or 131−seg (m=1). An out-of-range page or segment gives 8'h00.
- R12: After reset, the page is 0, the column is 0, the mirror bit is 0, the holding latch is 8'h00 and d_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_68 | input | 1 | Bus timing strap: 0 strobe pair, 1 enable plus read/write |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| a0 | input | 1 | 1 display data, 0 command or status |
| rd_e | input | 1 | Read strobe (mode 0, active low) or enable (mode 1) |
| wr_rw | input | 1 | Write strobe (mode 0, active low) or read/write level (mode 1) |
| d_in | input | 8 | Host write data |
| d_out | output | 8 | Host read data |
| d_oe | output | 1 | Host data bus drive enable |
| scan_page | input | PW | Scan port page index |
| scan_seg | input | CW | Scan port segment index |
| scan_data | output | 8 | Scan port byte, one clock latency |

## Verification
The bench fills the whole memory with an arithmetic pattern and sweeps every page and segment through the scan port, once with the mirror bit clear and once with it set. An off-by-one in the mirror or in the page stride would corrupt whole rows of this sweep. It drives the column into its last position on both reads and writes. A counter that wraps would overwrite column 0, and one that carries would spill into the next page. It checks the dummy-read offset before and after status reads: a design that read memory directly would return the data one read early, and a status read that touched the latch or column would shift the rest of the sequence. Deselected strobes, out-of-range page commands, clamped column values and both bus timing styles are each followed by a scan or read that shows whether stray state was disturbed.

// File: rtl/disp_ram_port.sv
module disp_ram_port #(
  parameter int PAGES = 10,
  parameter int COLS  = 132,
  localparam int PW   = $clog2(PAGES + 1),
  localparam int CW   = $clog2(COLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_68,
  input  logic          cs1_n,
  input  logic          cs2,
  input  logic          a0,
  input  logic          rd_e,
  input  logic          wr_rw,
  input  logic [7:0]    d_in,
  output logic [7:0]    d_out,
  output logic          d_oe,
  input  logic [PW-1:0] scan_page,
  input  logic [CW-1:0] scan_seg,
  output logic [7:0]    scan_data
);
  localparam int DEPTH = PAGES * COLS;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [CW-1:0] LASTC  = CW'(COLS - 1);
  localparam logic [7:0]    LASTC8 = 8'(COLS - 1);
  localparam logic [PW-1:0] PLIM   = PW'(PAGES);

  logic [2:0] rd_sy, wr_sy, sel_sy;
  logic [PW-1:0] page;
  logic [CW-1:0] col;
  logic          mirror;
  logic [7:0]    holder;
  logic          wpend;
  logic [AW-1:0] waddr;
  logic [7:0]    mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_sy  <= {3{~mode_68}};
      wr_sy  <= '1;
      sel_sy <= '0;
    end else begin
      rd_sy  <= {rd_sy[1:0], rd_e};
      wr_sy  <= {wr_sy[1:0], wr_rw};
      sel_sy <= {sel_sy[1:0], ~cs1_n & cs2};
    end
  end

  wire sel_raw  = ~cs1_n & cs2;
  wire sel_s    = sel_sy[1];
  wire rd_act   = mode_68 ? (rd_sy[1] & wr_sy[1]) : ~rd_sy[1];
  wire rd_act_p = mode_68 ? (rd_sy[2] & wr_sy[2]) : ~rd_sy[2];
  wire rd_ev    = sel_s & rd_act & ~rd_act_p;
  wire wr_ev    = sel_s & (mode_68 ? (~rd_sy[1] & rd_sy[2] & ~wr_sy[1])
                                   : (wr_sy[1] & ~wr_sy[2]));
  wire dat_wr   = wr_ev & a0;
  wire cmd_wr   = wr_ev & ~a0;
  wire dat_rd   = rd_ev & a0;
  wire st_rd    = rd_ev & ~a0;

  assign d_oe = sel_raw & sel_s & rd_act;

  wire [AW-1:0] addr  = AW'(page) * AW'(COLS) + AW'(col);
  wire [7:0]    rdata = (wpend && waddr == addr) ? holder : mem[addr];

  function automatic logic [CW-1:0] clampc(input logic [7:0] v);
    return (v > LASTC8) ? LASTC : CW'(v);
  endfunction

  wire [7:0] col8 = 8'(col);

  always_ff @(posedge clk) begin
    if (wpend) mem[waddr] <= holder;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page   <= '0;
      col    <= '0;
      mirror <= 1'b0;
      holder <= 8'h00;
      wpend  <= 1'b0;
      waddr  <= '0;
      d_out  <= 8'h00;
    end else begin
      wpend <= dat_wr;
      if (dat_wr) begin
        holder <= d_in;
        waddr  <= addr;
      end
      if (dat_rd) begin
        d_out  <= holder;
        holder <= rdata;
      end
      if (st_rd) d_out <= 8'h00;
      if ((dat_wr || dat_rd) && col != LASTC) col <= col + 1'b1;
      if (cmd_wr) begin
        casez (d_in)
          8'b1011_????: if (d_in[3:0] < 4'(PAGES)) page <= PW'(d_in[3:0]);
          8'b0000_????: col <= clampc({col8[7:4], d_in[3:0]});
          8'b0001_????: col <= clampc({d_in[3:0], col8[3:0]});
          8'b1010_000?: mirror <= d_in[0];
          default: ;
        endcase
      end
    end
  end

  wire          s_ok  = (scan_page < PLIM) && (scan_seg <= LASTC);
  wire [CW-1:0] s_col = mirror ? (LASTC - scan_seg) : scan_seg;
  wire [AW-1:0] s_adr = AW'(scan_page) * AW'(COLS) + AW'(s_col);

  always_ff @(posedge clk) begin
    if (!rst_n) scan_data <= 8'h00;
    else        scan_data <= s_ok ? mem[s_adr] : 8'h00;
  end
endmodule

// File: rtl/disp_ram_port_chk.sv
module disp_ram_port_chk #(
  parameter int PAGES = 10,
  parameter int COLS  = 132,
  localparam int PW   = $clog2(PAGES + 1),
  localparam int CW   = $clog2(COLS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] page,
  input logic [CW-1:0] col,
  input logic          cmd_wr,
  input logic [7:0]    d_out,
  input logic          d_oe
);
  localparam logic [CW-1:0] LASTC = CW'(COLS - 1);
  localparam logic [PW-1:0] PLIM  = PW'(PAGES);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end
  wire live = (age == 2'd3);

  a_r2_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
    col <= LASTC);

  a_r2_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(cmd_wr)) |-> (col == $past(col) || col == CW'($past(col) + 1'b1)));

  a_r3_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
    page < PLIM);

  a_r6_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (live && d_oe && $past(d_oe) && $past(d_oe, 2)) |-> $stable(d_out));
endmodule

bind disp_ram_port disp_ram_port_chk #(.PAGES(PAGES), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .page(page), .col(col),
  .cmd_wr(cmd_wr), .d_out(d_out), .d_oe(d_oe)
);

// File: tb/tb_disp_ram_port.sv
`timescale 1ns/1ps
module tb_disp_ram_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_68 = 1'b0;
  logic cs1_n = 1'b1, cs2 = 1'b0, a0 = 1'b0;
  logic rd_e = 1'b1, wr_rw = 1'b1;
  logic [7:0] d_in = 8'h00;
  logic [7:0] d_out, scan_data;
  logic d_oe;
  logic [3:0] scan_page = '0;
  logic [7:0] scan_seg = '0;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  disp_ram_port dut (
    .clk(clk), .rst_n(rst_n), .mode_68(mode_68), .cs1_n(cs1_n), .cs2(cs2),
    .a0(a0), .rd_e(rd_e), .wr_rw(wr_rw), .d_in(d_in), .d_out(d_out),
    .d_oe(d_oe), .scan_page(scan_page), .scan_seg(scan_seg), .scan_data(scan_data)
  );

  function automatic logic [7:0] pat(input int p, input int c);
    return 8'(p * 37 + c * 5 + 3);
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle_bus();
    rd_e  = mode_68 ? 1'b0 : 1'b1;
    wr_rw = 1'b1;
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    mode_68 = m;
    idle_bus();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_write(input logic sel_a0, input logic [7:0] v);
    @(negedge clk);
    a0 = sel_a0; d_in = v;
    if (mode_68) begin
      wr_rw = 1'b0; rd_e = 1'b1;
      repeat (4) @(negedge clk);
      rd_e = 1'b0;
      repeat (5) @(negedge clk);
      wr_rw = 1'b1;
    end else begin
      wr_rw = 1'b0;
      repeat (4) @(negedge clk);
      wr_rw = 1'b1;
      repeat (5) @(negedge clk);
    end
  endtask

  task automatic bus_read(input logic sel_a0, output logic [7:0] v, output logic oe);
    @(negedge clk);
    a0 = sel_a0;
    if (mode_68) begin wr_rw = 1'b1; rd_e = 1'b1; end
    else rd_e = 1'b0;
    repeat (5) @(negedge clk);
    v = d_out; oe = d_oe;
    idle_bus();
    repeat (4) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] v);
    bus_write(1'b0, v);
  endtask

  task automatic scan(input int p, input int s, output logic [7:0] v);
    @(negedge clk);
    scan_page = 4'(p); scan_seg = 8'(s);
    @(negedge clk);
    v = scan_data;
  endtask

  task automatic set_addr(input int p, input int c);
    cmd(8'hB0 | 8'(p));
    cmd(8'h10 | 8'(c >> 4));
    cmd(8'h00 | 8'(c & 15));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic oe;

    // R12 reset state
    do_reset(1'b0);
    check("R12 d_oe idle after reset", {7'b0, d_oe}, 8'h00);
    cs1_n = 1'b0; cs2 = 1'b1;
    bus_read(1'b1, v, oe);
    check("R12 holder cleared", v, 8'h00);
    check("R8 d_oe during read", {7'b0, oe}, 8'h01);
    do_reset(1'b0);
    bus_write(1'b1, 8'h5A);
    scan(0, 0, v);
    check("R12 page0 col0 after reset", v, 8'h5A);

    // R1 R2 R5 fill every byte
    for (int p = 0; p < 10; p++) begin
      set_addr(p, 0);
      for (int c = 0; c < 132; c++) bus_write(1'b1, pat(p, c));
    end
    for (int p = 0; p < 10; p++)
      for (int s = 0; s < 132; s++) begin
        scan(p, s, v);
        check("R1 R11 scan normal", v, pat(p, s));
      end
    cmd(8'hA1);
    for (int p = 0; p < 10; p++)
      for (int s = 0; s < 132; s++) begin
        scan(p, s, v);
        check("R11 scan mirrored", v, pat(p, 131 - s));
      end
    cmd(8'hA0);
    scan(10, 0, v);
    check("R11 page out of range", v, 8'h00);
    scan(2, 132, v);
    check("R11 seg out of range", v, 8'h00);

    // R6 R10 read pipeline and status
    set_addr(3, 0);
    bus_read(1'b1, v, oe);
    check("R6 dummy read returns last write", v, pat(9, 131));
    bus_read(1'b1, v, oe);
    check("R6 read col0", v, pat(3, 0));
    bus_read(1'b1, v, oe);
    check("R6 read col1", v, pat(3, 1));
    bus_read(1'b0, v, oe);
    check("R10 status busy clear", v, 8'h00);
    bus_read(1'b1, v, oe);
    check("R10 status left column and latch", v, pat(3, 2));

    // R2 read saturation
    set_addr(4, 130);
    bus_read(1'b1, v, oe);
    bus_read(1'b1, v, oe);
    check("R2 read col130", v, pat(4, 130));
    bus_read(1'b1, v, oe);
    check("R2 read col131", v, pat(4, 131));
    bus_read(1'b1, v, oe);
    check("R2 read saturated", v, pat(4, 131));

    // R2 R3 write saturation, no page carry
    set_addr(5, 129);
    bus_write(1'b1, 8'h11);
    bus_write(1'b1, 8'h22);
    bus_write(1'b1, 8'h33);
    bus_write(1'b1, 8'h44);
    scan(5, 129, v); check("R2 write col129", v, 8'h11);
    scan(5, 130, v); check("R2 write col130", v, 8'h22);
    scan(5, 131, v); check("R2 write saturated col131", v, 8'h44);
    scan(6, 0, v);   check("R3 no carry into next page", v, pat(6, 0));
    scan(5, 0, v);   check("R2 no wrap to col0", v, pat(5, 0));

    // R3 invalid page ignored
    cmd(8'hBC);
    cmd(8'h10); cmd(8'h00);
    bus_write(1'b1, 8'h77);
    scan(5, 0, v); check("R3 bad page kept old page", v, 8'h77);

    // R4 column nibbles and clamp
    cmd(8'h19); cmd(8'h0F);
    bus_write(1'b1, 8'h99);
    scan(5, 131, v); check("R4 column clamp", v, 8'h99);
    cmd(8'h14); cmd(8'h07);
    bus_write(1'b1, 8'hAB);
    scan(5, 71, v); check("R4 column nibbles", v, 8'hAB);

    // R7 deselect
    cs1_n = 1'b1;
    bus_write(1'b1, 8'hEE);
    bus_read(1'b1, v, oe);
    check("R7 d_oe off with cs1_n high", {7'b0, oe}, 8'h00);
    cs1_n = 1'b0; cs2 = 1'b0;
    bus_write(1'b1, 8'hEF);
    bus_read(1'b1, v, oe);
    check("R7 d_oe off with cs2 low", {7'b0, oe}, 8'h00);
    cs2 = 1'b1;
    scan(5, 72, v); check("R7 deselected write ignored", v, pat(5, 72));
    bus_write(1'b1, 8'h5C);
    scan(5, 72, v); check("R7 column unmoved while deselected", v, 8'h5C);

    // R9 second timing style, R12 mirror cleared by reset
    cmd(8'hA1);
    do_reset(1'b1);
    scan(7, 0, v); check("R12 mirror cleared", v, pat(7, 0));
    set_addr(7, 5);
    bus_write(1'b1, 8'hC3);
    scan(7, 5, v); check("R9 enable-style write", v, 8'hC3);
    set_addr(7, 5);
    bus_read(1'b1, v, oe);
    check("R9 dummy read holds written byte", v, 8'hC3);
    bus_read(1'b1, v, oe);
    check("R9 enable-style read", v, 8'hC3);
    check("R9 d_oe during read", {7'b0, oe}, 8'h01);
    bus_read(1'b1, v, oe);
    check("R9 read next column", v, pat(7, 6));
    bus_read(1'b0, v, oe);
    check("R10 status in enable style", v, 8'h00);

    finish_run();
  end
endmodule